// File: doc/BRIEF.md
# Small-Page NAND Flash Bus Front End

This block is the device side of an 8-bit, small-page NAND flash bus. On every write strobe it looks at the chip-enable, command-latch and address-latch pins and sorts the byte on the bus into one of three kinds: a command opcode, an address byte or a data byte. It decodes the opcode set and assembles the column and row from the address bytes. It starts a page read, opens a program buffer, fires a program or erase, or switches the bus to status or identification output when the right byte arrives.

The storage array and the program/erase engine are outside the block. A page read is announced with a one-cycle `page_load` pulse. Read bytes are fetched from the array through a combinational read port addressed by `arr_row`/`arr_col`. Program data leaves the block as one-cycle write pulses that carry their own column. Timing of the array is not modelled, so the ready output is always high. Each read strobe returns one byte on `bus_out` in the cycle after the strobe.

Top module: `nandfe_top`

## Requirements
- R1: A write strobe with chip_en_n low is a command when cmd_latch is high. It is an address byte when cmd_latch is low and addr_latch is high, and a data byte when both are low. Write strobes with chip_en_n high have no effect.
- R2: Address bytes fill 8-bit slots least significant first: byte 0 is the column, and bytes 1 and 2 form the 16-bit row with byte 1 as its low half. Every command byte restarts the slot count at 0. Bytes beyond the fourth are dropped.
- R3: Opcodes 0x00, 0x01 and 0x50 select read with a starting column offset of 0, 256 and the page size (512) respectively. The third address byte after such an opcode launches the read. page_load pulses one cycle after that strobe, with arr_row = row and arr_col = column byte + offset.
- R4: In read mode each read strobe returns arr_rdata at the current (arr_row, arr_col) on bus_out one cycle later, then advances the column. After column 527 (page plus 16 spare bytes) the column wraps to 0, the row increments and page_load pulses.
- R5: A read whose starting column is 528 or more issues no page_load, and its reads return 0x00.
- R6: After opcode 0x90 and one address byte, reads return 0x5A, 0x3D, 0xA5 and 0xC0 in that order, then 0x00. Before the address byte they return 0x00.
- R7: After opcode 0x70 every read returns the status byte without advancing any pointer. Bit 7 equals wr_prot_n at the time of the read, bit 6 (ready) is 1, and all other bits are 0.
- R8: Opcode 0xFF returns to read mode with no data pending, and clears the address slots and the column offset. A following three-byte address with no read opcode launches at the raw column byte.
- R9: A read strobe with chip_en_n high returns 0x00 and does not advance the column.
- R10: After 0x80 and three address bytes, each data byte yields a pgm_wr pulse one cycle later with pgm_data and pgm_col. The first column is the column byte plus the pending offset, and the column then increments. Data bytes before the third address byte, or at column 528 and above, are dropped.
- R11: Opcode 0x10 after an opened program pulses pgm_go one cycle later with arr_row = program row, only if wr_prot_n is high.
- R12: Opcode 0xD0 directly after 0x60 pulses ers_go with arr_row formed from the address bytes received since 0x60. Slot 0 is the row low byte, and slots not received read as 0. There is no pulse when wr_prot_n is low or when 0x60 did not precede.
- R13: An opcode outside the defined set leaves mode, pointers and output unchanged, apart from restarting the address slot count.
- R14: ready is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en_n | input | 1 | Active-low chip enable |
| cmd_latch | input | 1 | Marks a written byte as a command |
| addr_latch | input | 1 | Marks a written byte as an address byte |
| wr_prot_n | input | 1 | Active-low write protect |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| bus_in | input | 8 | Byte written by the host |
| bus_out | output | 8 | Byte returned by the last read strobe |
| ready | output | 1 | Ready/busy, always ready |
| page_load | output | 1 | Pulse: array should load arr_row |
| arr_row | output | 16 | Current page row |
| arr_col | output | 10 | Current read column |
| arr_rdata | input | 8 | Array byte at arr_row/arr_col |
| pgm_wr | output | 1 | Pulse: buffer write of pgm_data |
| pgm_col | output | 10 | Column of the buffer write |
| pgm_data | output | 8 | Byte of the buffer write |
| pgm_go | output | 1 | Pulse: program arr_row |
| ers_go | output | 1 | Pulse: erase arr_row |

## Verification
The hardest state to reach is the page-boundary crossing of a streaming read, which the bench cannot get to by ordinary reads without hundreds of strobes. The bench uses the spare-area read opcode with a column byte of 0x0E, so the stream starts two bytes before the end of the 528-byte page. The third read must then come from row+1 column 0 together with a page_load pulse. The same offset trick pushes a program buffer to its end and a read start past it, to cover the drop and empty cases.

// File: rtl/nandfe_pkg.sv
package nandfe_pkg;

   localparam logic [7:0] OP_READ_MAIN  = 8'h00;
   localparam logic [7:0] OP_READ_HALF  = 8'h01;
   localparam logic [7:0] OP_READ_SPARE = 8'h50;
   localparam logic [7:0] OP_IDENT      = 8'h90;
   localparam logic [7:0] OP_RESET      = 8'hFF;
   localparam logic [7:0] OP_PGM_SETUP  = 8'h80;
   localparam logic [7:0] OP_PGM_CONF   = 8'h10;
   localparam logic [7:0] OP_ERS_SETUP  = 8'h60;
   localparam logic [7:0] OP_ERS_CONF   = 8'hD0;
   localparam logic [7:0] OP_STATUS     = 8'h70;

   // status byte bit positions
   localparam int ST_FAIL_BIT = 0;
   localparam int ST_RDY_BIT  = 6;
   localparam int ST_WEN_BIT  = 7;

   typedef enum logic [2:0] {
      MD_READ,
      MD_IDENT,
      MD_STAT,
      MD_PGM,
      MD_PGM_DONE,
      MD_ERS,
      MD_ERS_DONE
   } mode_t;

   typedef struct packed {
      logic cmd;
      logic adr;
      logic dat;
      logic rd;
      logic rd_off;
   } strobe_t;

endpackage

// File: rtl/nandfe_sort.sv
module nandfe_sort
   import nandfe_pkg::*;
(
   input  logic    wr_stb,
   input  logic    rd_stb,
   input  logic    chip_en_n,
   input  logic    cmd_latch,
   input  logic    addr_latch,
   output strobe_t stb
);

   always_comb begin
      stb.cmd    = wr_stb && !chip_en_n && cmd_latch;
      stb.adr    = wr_stb && !chip_en_n && !cmd_latch && addr_latch;
      stb.dat    = wr_stb && !chip_en_n && !cmd_latch && !addr_latch;
      stb.rd     = rd_stb && !chip_en_n;
      stb.rd_off = rd_stb && chip_en_n;
   end

endmodule

// File: rtl/nandfe_addr.sv
module nandfe_addr #(
   parameter int ADDR_BYTES = 4,
   localparam int AW = 8 * ADDR_BYTES,
   localparam int CW = $clog2(ADDR_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adr_stb,
   input  logic          cmd_stb,
   input  logic          clr,
   input  logic [7:0]    din,
   output logic [AW-1:0] addr_nxt,
   output logic [AW-1:0] addr_masked,
   output logic [CW-1:0] cnt_q
);

   logic [AW-1:0] addr_q;

   for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_slot
      assign addr_nxt[8*i +: 8] =
         (adr_stb && cnt_q == CW'(i)) ? din : addr_q[8*i +: 8];
      assign addr_masked[8*i +: 8] =
         (cnt_q > CW'(i)) ? addr_q[8*i +: 8] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (clr) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (cmd_stb) begin
         cnt_q  <= '0;
      end else if (adr_stb && cnt_q < CW'(ADDR_BYTES)) begin
         addr_q <= addr_nxt;
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assert_cmd_clears_count_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |=> cnt_q == '0);

   assert_count_steps_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (adr_stb && cnt_q < CW'(ADDR_BYTES)) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/nandfe_idrom.sv
module nandfe_idrom #(
   parameter logic [7:0] MFR_ID  = 8'h5A,
   parameter logic [7:0] DEV_ID  = 8'h3D,
   parameter logic [7:0] FILL_ID = 8'hA5,
   parameter logic [7:0] LAST_ID = 8'hC0
) (
   input  logic [1:0] idx,
   output logic [7:0] id_byte
);

   always_comb begin
      case (idx)
         2'd0:    id_byte = MFR_ID;
         2'd1:    id_byte = DEV_ID;
         2'd2:    id_byte = FILL_ID;
         default: id_byte = LAST_ID;
      endcase
   end

endmodule

// File: rtl/nandfe_ctrl.sv
module nandfe_ctrl
   import nandfe_pkg::*;
#(
   parameter int PAGE_BYTES   = 512,
   parameter int SPARE_BYTES  = 16,
   parameter int ROW_W        = 16,
   parameter int ADDR_BYTES   = 4,
   parameter int LAUNCH_CYCLE = 3,
   localparam int AW    = 8 * ADDR_BYTES,
   localparam int CW    = $clog2(ADDR_BYTES + 1),
   localparam int TOTAL = PAGE_BYTES + SPARE_BYTES,
   localparam int COL_W = $clog2(PAGE_BYTES + SPARE_BYTES + 256)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  strobe_t          stb,
   input  logic [7:0]       bus_in,
   input  logic             wr_prot_n,
   input  logic [AW-1:0]    addr_nxt,
   input  logic [AW-1:0]    addr_masked,
   input  logic [CW-1:0]    cnt_q,
   input  logic [7:0]       arr_rdata,
   input  logic [7:0]       id_byte,
   output logic [1:0]       id_idx,
   output logic [7:0]       bus_out,
   output logic             page_load,
   output logic [ROW_W-1:0] arr_row,
   output logic [COL_W-1:0] arr_col,
   output logic             pgm_wr,
   output logic [COL_W-1:0] pgm_col,
   output logic [7:0]       pgm_data,
   output logic             pgm_go,
   output logic             ers_go
);

   mode_t            mode_q;
   logic             active_q, open_q;
   logic [COL_W-1:0] col_q, ofs_q, start_col;
   logic [ROW_W-1:0] row_q, start_row;
   logic [2:0]       idq;
   logic [7:0]       stat_byte;
   logic             launch;

   always_comb begin
      stat_byte              = 8'h00;
      stat_byte[ST_WEN_BIT]  = wr_prot_n;
      stat_byte[ST_RDY_BIT]  = 1'b1;
      stat_byte[ST_FAIL_BIT] = 1'b0;
   end

   assign start_col = COL_W'(addr_nxt[7:0]) + ofs_q;
   assign start_row = addr_nxt[8 +: ROW_W];
   assign launch    = stb.adr && cnt_q == CW'(LAUNCH_CYCLE - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MD_READ;
         active_q  <= 1'b0;
         open_q    <= 1'b0;
         col_q     <= '0;
         row_q     <= '0;
         ofs_q     <= '0;
         idq       <= 3'd4;
         bus_out   <= 8'h00;
         page_load <= 1'b0;
         pgm_wr    <= 1'b0;
         pgm_col   <= '0;
         pgm_data  <= 8'h00;
         pgm_go    <= 1'b0;
         ers_go    <= 1'b0;
      end else begin
         page_load <= 1'b0;
         pgm_wr    <= 1'b0;
         pgm_go    <= 1'b0;
         ers_go    <= 1'b0;

         if (stb.cmd) begin
            case (bus_in)
               OP_READ_MAIN, OP_READ_HALF, OP_READ_SPARE: begin
                  mode_q   <= MD_READ;
                  active_q <= 1'b0;
                  open_q   <= 1'b0;
                  ofs_q    <= (bus_in == OP_READ_MAIN) ? COL_W'(0) :
                              (bus_in == OP_READ_HALF) ? COL_W'(256) :
                                                         COL_W'(PAGE_BYTES);
               end
               OP_IDENT: begin
                  mode_q   <= MD_IDENT;
                  active_q <= 1'b0;
                  open_q   <= 1'b0;
                  idq      <= 3'd4;
               end
               OP_STATUS: begin
                  mode_q   <= MD_STAT;
                  active_q <= 1'b0;
                  open_q   <= 1'b0;
               end
               OP_RESET: begin
                  mode_q   <= MD_READ;
                  active_q <= 1'b0;
                  open_q   <= 1'b0;
                  ofs_q    <= '0;
                  col_q    <= '0;
                  row_q    <= '0;
               end
               OP_PGM_SETUP: begin
                  mode_q   <= MD_PGM;
                  active_q <= 1'b0;
                  open_q   <= 1'b0;
               end
               OP_PGM_CONF: begin
                  if (mode_q == MD_PGM && open_q && wr_prot_n) pgm_go <= 1'b1;
                  mode_q   <= MD_PGM_DONE;
                  active_q <= 1'b0;
                  open_q   <= 1'b0;
               end
               OP_ERS_SETUP: begin
                  mode_q   <= MD_ERS;
                  active_q <= 1'b0;
                  open_q   <= 1'b0;
               end
               OP_ERS_CONF: begin
                  if (mode_q == MD_ERS && wr_prot_n) begin
                     ers_go <= 1'b1;
                     row_q  <= addr_masked[ROW_W-1:0];
                  end
                  mode_q   <= MD_ERS_DONE;
                  active_q <= 1'b0;
                  open_q   <= 1'b0;
               end
               default: ;
            endcase
         end else if (stb.adr) begin
            if (mode_q == MD_IDENT && cnt_q == '0) idq <= 3'd0;
            if (launch && mode_q == MD_READ) begin
               row_q <= start_row;
               col_q <= start_col;
               ofs_q <= '0;
               if (start_col < COL_W'(TOTAL)) begin
                  active_q  <= 1'b1;
                  page_load <= 1'b1;
               end else begin
                  active_q  <= 1'b0;
               end
            end
            if (launch && mode_q == MD_PGM) begin
               row_q  <= start_row;
               col_q  <= start_col;
               ofs_q  <= '0;
               open_q <= 1'b1;
            end
         end else if (stb.dat) begin
            if (mode_q == MD_PGM && open_q && col_q < COL_W'(TOTAL)) begin
               pgm_wr   <= 1'b1;
               pgm_data <= bus_in;
               pgm_col  <= col_q;
               col_q    <= col_q + 1'b1;
            end
         end

         if (stb.rd_off) begin
            bus_out <= 8'h00;
         end else if (stb.rd) begin
            case (mode_q)
               MD_STAT: bus_out <= stat_byte;
               MD_IDENT: begin
                  if (idq < 3'd4) begin
                     bus_out <= id_byte;
                     idq     <= idq + 1'b1;
                  end else begin
                     bus_out <= 8'h00;
                  end
               end
               MD_READ: begin
                  if (active_q) begin
                     bus_out <= arr_rdata;
                     if (col_q == COL_W'(TOTAL - 1)) begin
                        col_q     <= '0;
                        row_q     <= row_q + 1'b1;
                        page_load <= 1'b1;
                     end else begin
                        col_q <= col_q + 1'b1;
                     end
                  end else begin
                     bus_out <= 8'h00;
                  end
               end
               default: bus_out <= 8'h00;
            endcase
         end
      end
   end

   assign arr_row = row_q;
   assign arr_col = col_q;
   assign id_idx  = idq[1:0];

   assert_ce_high_read_zero_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      stb.rd_off |=> (bus_out == 8'h00 && $stable(col_q)));

   assert_status_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (stb.rd && mode_q == MD_STAT) |=>
         (bus_out[ST_WEN_BIT] == $past(wr_prot_n) && bus_out[ST_RDY_BIT] && $stable(col_q)));

   assert_load_in_range_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      page_load |-> col_q < COL_W'(TOTAL));

   assert_pgm_col_range_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      pgm_wr |-> pgm_col < COL_W'(TOTAL));

   assert_pgm_protect_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      pgm_go |-> $past(wr_prot_n));

   assert_erase_protect_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      ers_go |-> $past(wr_prot_n));

   assert_single_pulse_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({page_load, pgm_go, ers_go}));

endmodule

// File: rtl/nandfe_top.sv
module nandfe_top
   import nandfe_pkg::*;
#(
   parameter int         PAGE_BYTES   = 512,
   parameter int         SPARE_BYTES  = 16,
   parameter int         ROW_W        = 16,
   parameter int         ADDR_BYTES   = 4,
   parameter int         LAUNCH_CYCLE = 3,
   parameter logic [7:0] MFR_ID       = 8'h5A,
   parameter logic [7:0] DEV_ID       = 8'h3D,
   parameter logic [7:0] FILL_ID      = 8'hA5,
   localparam int AW    = 8 * ADDR_BYTES,
   localparam int CW    = $clog2(ADDR_BYTES + 1),
   localparam int COL_W = $clog2(PAGE_BYTES + SPARE_BYTES + 256)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_en_n,
   input  logic             cmd_latch,
   input  logic             addr_latch,
   input  logic             wr_prot_n,
   input  logic             wr_stb,
   input  logic             rd_stb,
   input  logic [7:0]       bus_in,
   output logic [7:0]       bus_out,
   output logic             ready,
   output logic             page_load,
   output logic [ROW_W-1:0] arr_row,
   output logic [COL_W-1:0] arr_col,
   input  logic [7:0]       arr_rdata,
   output logic             pgm_wr,
   output logic [COL_W-1:0] pgm_col,
   output logic [7:0]       pgm_data,
   output logic             pgm_go,
   output logic             ers_go
);

   if (PAGE_BYTES < 256 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 256");
   end
   if (SPARE_BYTES < 1) begin : g_bad_spare
      $error("SPARE_BYTES must be positive");
   end
   if (LAUNCH_CYCLE < 2 || LAUNCH_CYCLE > ADDR_BYTES) begin : g_bad_launch
      $error("LAUNCH_CYCLE must lie between 2 and ADDR_BYTES");
   end
   if (ROW_W > 8 * (ADDR_BYTES - 1)) begin : g_bad_row
      $error("ROW_W does not fit in the row address bytes");
   end

   strobe_t       stb;
   logic [AW-1:0] addr_nxt, addr_masked;
   logic [CW-1:0] cnt_q;
   logic [1:0]    id_idx;
   logic [7:0]    id_byte;

   assign ready = 1'b1;

   nandfe_sort u_sort (
      .wr_stb     (wr_stb),
      .rd_stb     (rd_stb),
      .chip_en_n  (chip_en_n),
      .cmd_latch  (cmd_latch),
      .addr_latch (addr_latch),
      .stb        (stb)
   );

   nandfe_addr #(.ADDR_BYTES(ADDR_BYTES)) u_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .adr_stb     (stb.adr),
      .cmd_stb     (stb.cmd),
      .clr         (stb.cmd && bus_in == OP_RESET),
      .din         (bus_in),
      .addr_nxt    (addr_nxt),
      .addr_masked (addr_masked),
      .cnt_q       (cnt_q)
   );

   nandfe_idrom #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .FILL_ID(FILL_ID)) u_idrom (
      .idx     (id_idx),
      .id_byte (id_byte)
   );

   nandfe_ctrl #(
      .PAGE_BYTES   (PAGE_BYTES),
      .SPARE_BYTES  (SPARE_BYTES),
      .ROW_W        (ROW_W),
      .ADDR_BYTES   (ADDR_BYTES),
      .LAUNCH_CYCLE (LAUNCH_CYCLE)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .stb         (stb),
      .bus_in      (bus_in),
      .wr_prot_n   (wr_prot_n),
      .addr_nxt    (addr_nxt),
      .addr_masked (addr_masked),
      .cnt_q       (cnt_q),
      .arr_rdata   (arr_rdata),
      .id_byte     (id_byte),
      .id_idx      (id_idx),
      .bus_out     (bus_out),
      .page_load   (page_load),
      .arr_row     (arr_row),
      .arr_col     (arr_col),
      .pgm_wr      (pgm_wr),
      .pgm_col     (pgm_col),
      .pgm_data    (pgm_data),
      .pgm_go      (pgm_go),
      .ers_go      (ers_go)
   );

endmodule

// File: tb/sim_nandfe_top.sv
module sim_nandfe_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chip_en_n = 1'b0;
   logic       cmd_latch = 1'b0;
   logic       addr_latch = 1'b0;
   logic       wr_prot_n = 1'b1;
   logic       wr_stb = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] bus_in = 8'h00;
   logic [7:0] bus_out;
   logic       ready, page_load, pgm_wr, pgm_go, ers_go;
   logic [15:0] arr_row;
   logic [9:0]  arr_col, pgm_col;
   logic [7:0]  arr_rdata, pgm_data;

   int errs = 0;
   int checks = 0;

   // captured pulse values one cycle after a strobe
   logic        c_ld, c_pw, c_pg, c_eg;
   logic [9:0]  c_pc, c_col;
   logic [7:0]  c_pd;
   logic [15:0] c_row;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] arr_model(input logic [15:0] r, input logic [9:0] c);
      return (r[7:0] * 8'h1F) ^ c[7:0] ^ {c[9:8], 6'b0};
   endfunction

   assign arr_rdata = arr_model(arr_row, arr_col);

   nandfe_top u0 (
      .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .cmd_latch(cmd_latch),
      .addr_latch(addr_latch), .wr_prot_n(wr_prot_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .bus_in(bus_in), .bus_out(bus_out), .ready(ready), .page_load(page_load),
      .arr_row(arr_row), .arr_col(arr_col), .arr_rdata(arr_rdata), .pgm_wr(pgm_wr),
      .pgm_col(pgm_col), .pgm_data(pgm_data), .pgm_go(pgm_go), .ers_go(ers_go)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic capture();
      c_ld = page_load; c_pw = pgm_wr; c_pg = pgm_go; c_eg = ers_go;
      c_pc = pgm_col; c_pd = pgm_data; c_row = arr_row; c_col = arr_col;
   endtask

   // kind: 0 command, 1 address, 2 data
   task automatic wr(input int kind, input logic [7:0] b, input logic ce_hi = 1'b0);
      @(negedge clk);
      chip_en_n  = ce_hi;
      cmd_latch  = (kind == 0);
      addr_latch = (kind == 1);
      bus_in     = b;
      wr_stb     = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0; cmd_latch = 1'b0; addr_latch = 1'b0; chip_en_n = 1'b0;
      capture();
   endtask

   task automatic rd(output logic [7:0] v, input logic ce_hi = 1'b0);
      @(negedge clk);
      chip_en_n = ce_hi;
      rd_stb    = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0; chip_en_n = 1'b0;
      v = bus_out;
      capture();
   endtask

   task automatic t_reset_state();
      chk(bus_out, 8'h00, "R8 reset bus_out");
      chk(ready, 1'b1, "R14 ready");
      chk(page_load, 1'b0, "R3 no load at reset");
   endtask

   task automatic t_read_main();
      logic [7:0] v;
      wr(0, 8'h00);
      wr(1, 8'h10); chk(c_ld, 0, "R3 no launch on byte 1");
      wr(1, 8'h34);
      wr(1, 8'h12);
      chk(c_ld, 1, "R3 launch on third byte");
      chk(c_row, 16'h1234, "R2 row low byte first");
      chk(c_col, 10'h010, "R3 column offset 0");
      for (int i = 0; i < 3; i++) begin
         rd(v);
         chk(v, arr_model(16'h1234, 10'(16 + i)), "R4 sequential read");
      end
      chk(ready, 1'b1, "R14 ready during read");
   endtask

   task automatic t_read_half();
      logic [7:0] v;
      wr(0, 8'h01); wr(1, 8'h20); wr(1, 8'h07); wr(1, 8'h00);
      chk(c_col, 10'h120, "R3 half-page offset 256");
      rd(v);
      chk(v, arr_model(16'h0007, 10'h120), "R3 half-page data");
   endtask

   task automatic t_page_cross();
      logic [7:0] v;
      wr(0, 8'h50); wr(1, 8'h0E); wr(1, 8'h09); wr(1, 8'h00);
      chk(c_col, 10'd526, "R3 spare offset 512");
      rd(v); chk(v, arr_model(16'h0009, 10'd526), "R4 spare byte 526");
      chk(c_ld, 0, "R4 no load mid page");
      rd(v); chk(v, arr_model(16'h0009, 10'd527), "R4 last byte 527");
      chk(c_ld, 1, "R4 auto load at page end");
      chk(c_row, 16'h000A, "R4 row increments");
      rd(v); chk(v, arr_model(16'h000A, 10'd0), "R4 stream into next page");
   endtask

   task automatic t_spare_oob();
      logic [7:0] v;
      wr(0, 8'h50); wr(1, 8'h20); wr(1, 8'h01); wr(1, 8'h00);
      chk(c_ld, 0, "R5 no load past spare");
      rd(v); chk(v, 8'h00, "R5 read past spare is zero");
   endtask

   task automatic t_chip_disable();
      logic [7:0] v;
      wr(0, 8'h00); wr(1, 8'h40); wr(1, 8'h03); wr(1, 8'h00);
      rd(v, 1'b1); chk(v, 8'h00, "R9 read with chip disabled");
      wr(0, 8'h70, 1'b1);
      rd(v); chk(v, arr_model(16'h0003, 10'h040), "R9 R1 no advance, disabled write ignored");
      wr(0, 8'h42);
      rd(v); chk(v, arr_model(16'h0003, 10'h041), "R13 unknown opcode keeps read");
   endtask

   task automatic t_ident();
      logic [7:0] v;
      wr(0, 8'h90);
      rd(v); chk(v, 8'h00, "R6 no id before address");
      wr(1, 8'h00);
      rd(v); chk(v, 8'h5A, "R6 id byte 0");
      rd(v); chk(v, 8'h3D, "R6 id byte 1");
      rd(v); chk(v, 8'hA5, "R6 id byte 2");
      rd(v); chk(v, 8'hC0, "R6 id byte 3");
      rd(v); chk(v, 8'h00, "R6 id exhausted");
   endtask

   task automatic t_status();
      logic [7:0] v;
      wr_prot_n = 1'b1;
      wr(0, 8'h70);
      rd(v); chk(v, 8'hC0, "R7 status unprotected");
      rd(v); chk(v, 8'hC0, "R7 status repeats");
      wr_prot_n = 1'b0;
      rd(v); chk(v, 8'h40, "R7 status follows protect");
      wr_prot_n = 1'b1;
      wr(0, 8'h42);
      rd(v); chk(v, 8'hC0, "R13 unknown opcode keeps status");
   endtask

   task automatic t_soft_reset();
      logic [7:0] v;
      wr(0, 8'h00); wr(1, 8'h05); wr(1, 8'h02); wr(1, 8'h00);
      wr(0, 8'hFF);
      rd(v); chk(v, 8'h00, "R8 no data after reset");
      wr(0, 8'h50); wr(0, 8'hFF);
      wr(1, 8'h04); wr(1, 8'h02); wr(1, 8'h00);
      chk(c_ld, 1, "R8 read mode after reset");
      chk(c_col, 10'd4, "R8 offset cleared");
   endtask

   task automatic t_program();
      wr_prot_n = 1'b1;
      wr(0, 8'h80);
      wr(2, 8'h77); chk(c_pw, 0, "R10 data before open dropped");
      wr(1, 8'h08); wr(1, 8'h09); wr(1, 8'h00);
      wr(2, 8'hAA);
      chk(c_pw, 1, "R10 data write pulse");
      chk(c_pc, 10'd8, "R10 first column");
      chk(c_pd, 8'hAA, "R10 first data");
      wr(2, 8'hBB);
      chk(c_pc, 10'd9, "R10 column increments");
      wr(0, 8'h10);
      chk(c_pg, 1, "R11 program fires");
      chk(c_row, 16'h0009, "R11 program row");
   endtask

   task automatic t_program_protected();
      wr_prot_n = 1'b0;
      wr(0, 8'h80); wr(1, 8'h00); wr(1, 8'h01); wr(1, 8'h00);
      wr(2, 8'h11);
      wr(0, 8'h10);
      chk(c_pg, 0, "R11 program blocked by protect");
      wr_prot_n = 1'b1;
   endtask

   task automatic t_program_end();
      wr(0, 8'h50); wr(0, 8'h80); wr(1, 8'h0E); wr(1, 8'h02); wr(1, 8'h00);
      wr(2, 8'h01); chk(c_pc, 10'd526, "R10 spare program column");
      wr(2, 8'h02); chk(c_pw, 1, "R10 last column accepted");
      wr(2, 8'h03); chk(c_pw, 0, "R10 beyond buffer dropped");
   endtask

   task automatic t_erase();
      wr_prot_n = 1'b1;
      wr(0, 8'h60); wr(1, 8'h34); wr(1, 8'h12); wr(0, 8'hD0);
      chk(c_eg, 1, "R12 erase fires");
      chk(c_row, 16'h1234, "R12 erase row");
      wr(0, 8'h60); wr(1, 8'h56); wr(0, 8'hD0);
      chk(c_row, 16'h0056, "R12 missing byte reads zero");
      wr(0, 8'hD0);
      chk(c_eg, 0, "R12 confirm without setup");
      wr_prot_n = 1'b0;
      wr(0, 8'h60); wr(1, 8'h01); wr(0, 8'hD0);
      chk(c_eg, 0, "R12 erase blocked by protect");
      wr_prot_n = 1'b1;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_read_main();
      t_read_half();
      t_page_cross();
      t_spare_oob();
      t_chip_disable();
      t_ident();
      t_status();
      t_soft_reset();
      t_program();
      t_program_protected();
      t_program_end();
      t_erase();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule